// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block models a parallel NOR flash array behind a command-driven bus in synthesizable form. Bus writes are interpreted as command bytes (taken from the low byte of the write data) by a small sequencer. The sequencer holds a write-cycle phase, the current command and an 8-bit status register. Depending on the current command, a read returns array contents, the status byte, identification codes or query-table bytes. Program, erase and buffered write all finish in a single clock, so the status ready bit never drops.

The bus is byte-addressed. An access is either wide (the full bus word, with the address aligned down to the bus width) or narrow (one byte at the exact address, in data bits 7:0). The bus word is made of one or more device lanes. Status, identification and query answers are copied into every device lane. A configuration input picks the byte order used to map a wide word onto the byte array. When the secure option is built in, accesses marked non-secure bypass the interpreter. Such reads always see the array, and such writes are dropped.

Read data is registered: `rd_data` holds the answer in the cycle after `bus_rd` is sampled. A write and a read in the same cycle see the state from before the write.

Top module: `nor_cmd_flash`

## Requirements
- R1: After reset, the array reads 0xFF in every byte, the interpreter is in array-read mode and the status byte is 0x80.
- R2: Writing 0x10 or 0x40 arms a program. The next write stores its data (wide or narrow) and ORs 0x80 into status. While the command is program, reads return status.
- R3: With `prot` high, the data write of a program leaves the array unchanged and ORs 0x10 and 0x80 into status.
- R4: Writing 0x20 or 0x28 and then 0xD0 fills the whole SECTOR_BYTES-aligned sector holding the second write's address with 0xFF and ORs 0x80 into status. Other sectors keep their data. If the second write is 0xFF instead, nothing is erased and array-read mode is entered.
- R5: With `prot` high, a confirmed erase leaves the array unchanged and ORs 0x20 and 0x80 into status.
- R6: 0x50 clears status to 0x00 and selects status reads. 0x70 selects status reads. 0xFF selects array reads.
- R7: A wide read in status mode returns the status byte, zero-extended to each device lane, in every lane. A narrow read returns the status in bits 7:0.
- R8: 0x60 followed by 0x01 or 0xD0 ORs 0x80 into status and keeps status reads. Any other second byte enters array-read mode.
- R9: 0xE8 ORs 0x80 into status. The next write's low DEV_BYTES*8 bits give N, and the following N+1 writes program data. The write after that must be 0xD0, which ORs 0x80 into status. Any other value there enters array-read mode, and the data already written stays.
- R10: After 0x90, a read at index i = address >> log2(BUS_BYTES) returns MFR_ID when i=0, DEV_ID when i=1 and 0 otherwise, copied into each device lane.
- R11: After 0x98, indices 0x10, 0x11 and 0x12 read 0x51, 0x52 and 0x59 in each lane. The next write of any value enters array-read mode.
- R12: An unrecognised command byte in the idle phase enters array-read mode.
- R13: With `cfg_msb_first` = 1, the byte at the lowest address of a wide word is its most significant byte. With 0, it is the least significant byte.
- R14: With SECURE_EN set and `bus_secure` low, reads return array data whatever the mode, and writes change neither the mode nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wide | input | 1 | 1 = full-word access, 0 = single-byte access |
| bus_wr | input | 1 | Write strobe, one per cycle |
| bus_wdata | input | 8*BUS_BYTES | Write data; command byte in bits 7:0 |
| bus_rd | input | 1 | Read strobe |
| bus_secure | input | 1 | Access is secure |
| prot | input | 1 | Array write-protect |
| cfg_msb_first | input | 1 | Byte order of wide words |
| rd_data | output | 8*BUS_BYTES | Registered read data |

## Verification
A wrong phase or command register shows up on the very next read. Status, ID or query bytes appear where array data was expected, or the other way round. A lost or extra buffered data write shows up later, when the buffered words are read back and differ. A stray erase or program enable corrupts array bytes that a later randomized readback compares against a byte-level model. A status bit that is set wrongly appears on the first status read after the operation.

// File: rtl/fl_pkg.sv
// Shared command codes, status bits and state types for the flash interpreter.
// Assumes command bytes arrive in the low byte of a bus write.
package fl_pkg;

    localparam logic [7:0] OP_PROG_A   = 8'h10;
    localparam logic [7:0] OP_PROG_B   = 8'h40;
    localparam logic [7:0] OP_ERASE_A  = 8'h20;
    localparam logic [7:0] OP_ERASE_B  = 8'h28;
    localparam logic [7:0] OP_CLEAR    = 8'h50;
    localparam logic [7:0] OP_LOCK     = 8'h60;
    localparam logic [7:0] OP_LOCK_SET = 8'h01;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_IDENT    = 8'h90;
    localparam logic [7:0] OP_QUERY    = 8'h98;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;
    localparam logic [7:0] OP_BUFFER   = 8'hE8;
    localparam logic [7:0] OP_ARRAY    = 8'hFF;
    localparam logic [7:0] OP_IDLECMD  = 8'h00;

    localparam logic [7:0] ST_READY     = 8'h80;
    localparam logic [7:0] ST_ERASE_ERR = 8'h20;
    localparam logic [7:0] ST_PROG_ERR  = 8'h10;

    typedef enum logic [1:0] {
        RD_ARRAY,
        RD_STATUS,
        RD_IDENT,
        RD_QUERY
    } rd_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ARG,
        PH_FILL,
        PH_CONFIRM
    } phase_e;

endpackage

// File: rtl/fl_cmd_seq.sv
// Command sequencer: tracks the write phase, current command, status byte
// and buffered-write counter. It issues single-cycle program/erase strobes
// to the array. Assumes wr_go is already gated by the secure option.
module fl_cmd_seq
    import fl_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_go,
    input  logic [7:0]       wr_byte,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             prot,
    output logic             prog_req,
    output logic             erase_req,
    output rd_sel_e          rd_sel,
    output logic [7:0]       status
);

    phase_e           phase, nxt_phase;
    logic [7:0]       cur_cmd, nxt_cmd;
    logic [7:0]       nxt_stat;
    logic [CNT_W-1:0] count, nxt_cnt;
    logic             go_array;

    // Next-state decode of one bus write
    always_comb begin
        nxt_phase = phase;
        nxt_cmd   = cur_cmd;
        nxt_stat  = status;
        nxt_cnt   = count;
        prog_req  = 1'b0;
        erase_req = 1'b0;
        go_array  = 1'b0;
        if (wr_go) begin
            case (phase)
                PH_IDLE: begin
                    case (wr_byte)
                        OP_PROG_A, OP_PROG_B, OP_ERASE_A, OP_ERASE_B,
                        OP_LOCK, OP_QUERY: begin
                            nxt_cmd   = wr_byte;
                            nxt_phase = PH_ARG;
                        end
                        OP_CLEAR: begin
                            nxt_cmd  = wr_byte;
                            nxt_stat = 8'h00;
                        end
                        OP_STATUS, OP_IDENT: nxt_cmd = wr_byte;
                        OP_BUFFER: begin
                            nxt_cmd   = wr_byte;
                            nxt_stat  = status | ST_READY;
                            nxt_phase = PH_ARG;
                        end
                        default: go_array = 1'b1;
                    endcase
                end
                PH_ARG: begin
                    case (cur_cmd)
                        OP_PROG_A, OP_PROG_B: begin
                            if (prot) nxt_stat = status | ST_PROG_ERR | ST_READY;
                            else begin
                                prog_req = 1'b1;
                                nxt_stat = status | ST_READY;
                            end
                            nxt_phase = PH_IDLE;
                        end
                        OP_ERASE_A, OP_ERASE_B: begin
                            if (wr_byte == OP_CONFIRM) begin
                                if (prot) nxt_stat = status | ST_ERASE_ERR | ST_READY;
                                else begin
                                    erase_req = 1'b1;
                                    nxt_stat  = status | ST_READY;
                                end
                                nxt_phase = PH_IDLE;
                            end else begin
                                go_array = 1'b1;
                            end
                        end
                        OP_LOCK: begin
                            if (wr_byte == OP_LOCK_SET || wr_byte == OP_CONFIRM) begin
                                nxt_stat  = status | ST_READY;
                                nxt_phase = PH_IDLE;
                            end else begin
                                go_array = 1'b1;
                            end
                        end
                        OP_BUFFER: begin
                            nxt_cnt   = cnt_in;
                            nxt_stat  = status | ST_READY;
                            nxt_phase = PH_FILL;
                        end
                        default: go_array = 1'b1;
                    endcase
                end
                PH_FILL: begin
                    if (prot) nxt_stat = status | ST_PROG_ERR;
                    else      prog_req = 1'b1;
                    if (count == '0) nxt_phase = PH_CONFIRM;
                    else             nxt_cnt   = count - 1'b1;
                end
                default: begin
                    if (wr_byte == OP_CONFIRM) begin
                        nxt_stat  = status | ST_READY;
                        nxt_phase = PH_IDLE;
                    end else begin
                        go_array = 1'b1;
                    end
                end
            endcase
            if (go_array) begin
                nxt_phase = PH_IDLE;
                nxt_cmd   = OP_IDLECMD;
            end
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cur_cmd <= OP_IDLECMD;
            status  <= ST_READY;
            count   <= '0;
        end else begin
            phase   <= nxt_phase;
            cur_cmd <= nxt_cmd;
            status  <= nxt_stat;
            count   <= nxt_cnt;
        end
    end

    // Read source selected by the current command
    always_comb begin
        case (cur_cmd)
            OP_PROG_A, OP_PROG_B, OP_ERASE_A, OP_ERASE_B, OP_CLEAR,
            OP_LOCK, OP_STATUS, OP_BUFFER: rd_sel = RD_STATUS;
            OP_IDENT:                      rd_sel = RD_IDENT;
            OP_QUERY:                      rd_sel = RD_QUERY;
            default:                       rd_sel = RD_ARRAY;
        endcase
    end

    p_ready_after_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> status[7]);

    p_prog_err_needs_prot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[4]) |-> $past(prot));

    p_erase_err_needs_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[5]) |-> $past(prot));

    p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && phase == PH_IDLE && wr_byte == OP_CLEAR) |=> (status == 8'h00));

    p_fill_only_buffer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FILL || phase == PH_CONFIRM) |-> (cur_cmd == OP_BUFFER));

endmodule

// File: rtl/fl_array.sv
// Byte-organised storage with word program, sector erase and word/byte read.
// Assumes SECTOR_BYTES and BUS_BYTES are powers of two dividing MEM_BYTES.
// Reset leaves every byte erased (0xFF).
module fl_array #(
    parameter int MEM_BYTES    = 256,
    parameter int SECTOR_BYTES = 64,
    parameter int BUS_BYTES    = 2,
    parameter int ADDR_W       = $clog2(MEM_BYTES),
    parameter int BUS_W        = 8 * BUS_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              msb_first,
    output logic [BUS_W-1:0]  rdata
);

    localparam logic [ADDR_W-1:0] WORD_MASK = ADDR_W'(BUS_BYTES - 1);
    localparam logic [ADDR_W-1:0] SEC_MASK  = ADDR_W'(SECTOR_BYTES - 1);

    logic [7:0]        mem [MEM_BYTES];
    logic [ADDR_W-1:0] word_base;
    logic [ADDR_W-1:0] sec_base;

    assign word_base = addr & ~WORD_MASK;
    assign sec_base  = addr & ~SEC_MASK;

    // Lane of the bus word that maps to byte k of an aligned word
    function automatic int lane_of(input int k, input logic msb);
        return msb ? (BUS_BYTES - 1 - k) : k;
    endfunction

    // Storage update: reset fill, sector erase or program
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
        end else if (erase) begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                if ((ADDR_W'(i) & ~SEC_MASK) == sec_base) mem[i] <= 8'hFF;
            end
        end else if (prog) begin
            if (wide) begin
                for (int k = 0; k < BUS_BYTES; k++)
                    mem[word_base + ADDR_W'(k)] <= wdata[8*lane_of(k, msb_first) +: 8];
            end else begin
                mem[addr] <= wdata[7:0];
            end
        end
    end

    // Read assembly in the configured byte order
    always_comb begin
        rdata = '0;
        if (wide) begin
            for (int k = 0; k < BUS_BYTES; k++)
                rdata[8*lane_of(k, msb_first) +: 8] = mem[word_base + ADDR_W'(k)];
        end else begin
            rdata[7:0] = mem[addr];
        end
    end

    p_erase_fills_sector_r4: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (mem[$past(sec_base)] == 8'hFF));

endmodule

// File: rtl/fl_info.sv
// Identification and query answer generator. It forms one device-lane answer
// from the table index and copies it into every device lane of the bus.
// Assumes BUS_BYTES is a multiple of DEV_BYTES.
module fl_info #(
    parameter int          BUS_BYTES    = 2,
    parameter int          DEV_BYTES    = 1,
    parameter int          MEM_BYTES    = 256,
    parameter int          SECTOR_BYTES = 64,
    parameter logic [15:0] MFR_ID       = 16'h0089,
    parameter logic [15:0] DEV_ID       = 16'h0018,
    parameter int          BUS_W        = 8 * BUS_BYTES
) (
    input  logic [7:0]       idx,
    input  logic             is_query,
    output logic [BUS_W-1:0] word
);

    localparam int DEV_W     = 8 * DEV_BYTES;
    localparam int NDEV      = BUS_BYTES / DEV_BYTES;
    localparam int SIZE_LOG2 = $clog2(MEM_BYTES / NDEV);
    localparam int NBLK      = MEM_BYTES / SECTOR_BYTES;

    logic [7:0]       qbyte;
    logic [DEV_W-1:0] lane;

    // Query table byte for the index
    always_comb begin
        case (idx)
            8'h10:   qbyte = 8'h51;
            8'h11:   qbyte = 8'h52;
            8'h12:   qbyte = 8'h59;
            8'h13:   qbyte = 8'h01;
            8'h27:   qbyte = 8'(SIZE_LOG2);
            8'h2C:   qbyte = 8'h01;
            8'h2D:   qbyte = 8'(NBLK - 1);
            default: qbyte = 8'h00;
        endcase
    end

    // One device lane of the answer
    always_comb begin
        if (is_query) begin
            lane = DEV_W'(qbyte);
        end else begin
            case (idx)
                8'h00:   lane = MFR_ID[DEV_W-1:0];
                8'h01:   lane = DEV_ID[DEV_W-1:0];
                default: lane = '0;
            endcase
        end
    end

    for (genvar g = 0; g < NDEV; g++) begin : g_lane
        assign word[g*DEV_W +: DEV_W] = lane;
    end

endmodule

// File: rtl/nor_cmd_flash.sv
// Top of the flash command interpreter: gates non-secure accesses, drives the
// sequencer, array and info generator, and registers the selected read data.
// Assumes one bus write per cycle and power-of-two sizes.
module nor_cmd_flash
    import fl_pkg::*;
#(
    parameter int          MEM_BYTES    = 256,
    parameter int          SECTOR_BYTES = 64,
    parameter int          BUS_BYTES    = 2,
    parameter int          DEV_BYTES    = 1,
    parameter bit          SECURE_EN    = 1'b1,
    parameter logic [15:0] MFR_ID       = 16'h0089,
    parameter logic [15:0] DEV_ID       = 16'h0018,
    parameter int          ADDR_W       = $clog2(MEM_BYTES),
    parameter int          BUS_W        = 8 * BUS_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wide,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_secure,
    input  logic              prot,
    input  logic              cfg_msb_first,
    output logic [BUS_W-1:0]  rd_data
);

    localparam int DEV_W     = 8 * DEV_BYTES;
    localparam int NDEV      = BUS_BYTES / DEV_BYTES;
    localparam int BUS_SHIFT = $clog2(BUS_BYTES);

    logic             blocked;
    logic             wr_go;
    logic             prog_req, erase_req;
    rd_sel_e          rd_sel;
    logic [7:0]       status;
    logic [BUS_W-1:0] arr_word, info_word, stat_word, src_word;
    logic [7:0]       idx;

    assign blocked = SECURE_EN && !bus_secure;
    assign wr_go   = bus_wr && !blocked;
    assign idx     = 8'(bus_addr >> BUS_SHIFT);

    fl_cmd_seq #(.CNT_W(DEV_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (wr_go),
        .wr_byte   (bus_wdata[7:0]),
        .cnt_in    (bus_wdata[DEV_W-1:0]),
        .prot      (prot),
        .prog_req  (prog_req),
        .erase_req (erase_req),
        .rd_sel    (rd_sel),
        .status    (status)
    );

    fl_array #(
        .MEM_BYTES    (MEM_BYTES),
        .SECTOR_BYTES (SECTOR_BYTES),
        .BUS_BYTES    (BUS_BYTES),
        .ADDR_W       (ADDR_W),
        .BUS_W        (BUS_W)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog      (prog_req),
        .erase     (erase_req),
        .addr      (bus_addr),
        .wide      (bus_wide),
        .wdata     (bus_wdata),
        .msb_first (cfg_msb_first),
        .rdata     (arr_word)
    );

    fl_info #(
        .BUS_BYTES    (BUS_BYTES),
        .DEV_BYTES    (DEV_BYTES),
        .MEM_BYTES    (MEM_BYTES),
        .SECTOR_BYTES (SECTOR_BYTES),
        .MFR_ID       (MFR_ID),
        .DEV_ID       (DEV_ID),
        .BUS_W        (BUS_W)
    ) u_info (
        .idx      (idx),
        .is_query (rd_sel == RD_QUERY),
        .word     (info_word)
    );

    for (genvar g = 0; g < NDEV; g++) begin : g_stat
        assign stat_word[g*DEV_W +: DEV_W] = DEV_W'(status);
    end

    // Read source select
    always_comb begin
        if (blocked || rd_sel == RD_ARRAY) src_word = arr_word;
        else if (rd_sel == RD_STATUS)      src_word = stat_word;
        else                               src_word = info_word;
    end

    // Registered read data, narrow reads keep the low byte
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (bus_rd) rd_data <= bus_wide ? src_word : BUS_W'(src_word[7:0]);
    end

    p_secure_write_dropped_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && blocked) |=> ($stable(status) && $stable(rd_sel)));

    p_status_read_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !blocked && rd_sel == RD_STATUS) |=> (rd_data[7:0] == $past(status)));

endmodule

// File: tb/sim_nor_cmd_flash.sv
`timescale 1ns/1ps
module sim_nor_cmd_flash;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wide = 1'b1;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_secure = 1'b1;
    logic        prot = 1'b0;
    logic        cfg_msb_first = 1'b0;
    logic [15:0] rd_data;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;
    logic [7:0] mdl [256];

    always #10 clk = ~clk;

    nor_cmd_flash u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wide(bus_wide),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_secure(bus_secure), .prot(prot), .cfg_msb_first(cfg_msb_first),
        .rd_data(rd_data)
    );

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic wide, input logic sec);
        bus_addr = a; bus_wdata = d; bus_wide = wide; bus_secure = sec; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_secure = 1'b1;
    endtask

    task automatic cmd(input logic [7:0] a, input logic [15:0] d);
        wr(a, d, 1'b1, 1'b1);
    endtask

    task automatic chk(input string req, input logic [7:0] a, input logic wide,
                       input logic sec, input logic [15:0] exp);
        logic [15:0] got;
        bus_addr = a; bus_wide = wide; bus_secure = sec; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0; bus_secure = 1'b1;
        got = rd_data;
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s addr %h: got %h expected %h", req, a, got, exp);
        end
    endtask

    function automatic logic [15:0] mdl_word(input int a, input bit msb);
        int b = a & ~1;
        return msb ? {mdl[b], mdl[b+1]} : {mdl[b+1], mdl[b]};
    endfunction

    task automatic mdl_prog(input int a, input logic [15:0] d, input bit msb);
        int b = a & ~1;
        if (msb) begin mdl[b] = d[15:8]; mdl[b+1] = d[7:0]; end
        else     begin mdl[b] = d[7:0];  mdl[b+1] = d[15:8]; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1", 8'h00, 1, 1, 16'hFFFF);
        chk("R1", 8'hFE, 1, 1, 16'hFFFF);
        cmd(0, 16'h0070);
        chk("R1", 8'h00, 1, 1, 16'h8080);
        chk("R7", 8'h00, 0, 1, 16'h0080);

        // R2 program, little-endian order R13
        cfg_msb_first = 1'b0;
        cmd(0, 16'h0040);
        chk("R2", 8'h00, 1, 1, 16'h8080);
        cmd(8'h10, 16'h1234);
        cmd(0, 16'h00FF);
        chk("R2", 8'h10, 1, 1, 16'h1234);
        chk("R13", 8'h10, 0, 1, 16'h0034);
        chk("R13", 8'h11, 0, 1, 16'h0012);

        // R13 big-endian order
        cfg_msb_first = 1'b1;
        cmd(0, 16'h0010);
        cmd(8'h20, 16'hABCD);
        cmd(0, 16'h00FF);
        chk("R13", 8'h20, 1, 1, 16'hABCD);
        chk("R13", 8'h20, 0, 1, 16'h00AB);
        cfg_msb_first = 1'b0;

        // R3 protected program
        prot = 1'b1;
        cmd(0, 16'h0040);
        cmd(8'h10, 16'h0000);
        chk("R3", 8'h00, 1, 1, 16'h9090);
        cmd(0, 16'h00FF);
        chk("R3", 8'h10, 1, 1, 16'h1234);
        prot = 1'b0;

        // R6 clear status
        cmd(0, 16'h0050);
        chk("R6", 8'h00, 1, 1, 16'h0000);
        cmd(0, 16'h00FF);
        chk("R6", 8'h10, 1, 1, 16'h1234);

        // R4 erase abort and erase
        cmd(0, 16'h0040); cmd(8'h42, 16'h5555);
        cmd(0, 16'h0040); cmd(8'h80, 16'h6666);
        cmd(8'h42, 16'h0020); cmd(8'h42, 16'h00FF);
        chk("R4", 8'h42, 1, 1, 16'h5555);
        cmd(8'h42, 16'h0028); cmd(8'h7E, 16'h00D0);
        chk("R4", 8'h00, 1, 1, 16'h8080);
        cmd(0, 16'h00FF);
        chk("R4", 8'h42, 1, 1, 16'hFFFF);
        chk("R4", 8'h7E, 1, 1, 16'hFFFF);
        chk("R4", 8'h80, 1, 1, 16'h6666);
        chk("R4", 8'h10, 1, 1, 16'h1234);

        // R5 protected erase
        prot = 1'b1;
        cmd(8'h80, 16'h0020); cmd(8'h80, 16'h00D0);
        chk("R5", 8'h00, 1, 1, 16'hA0A0);
        cmd(0, 16'h00FF);
        chk("R5", 8'h80, 1, 1, 16'h6666);
        prot = 1'b0;

        // R8 lock / unlock / bad second byte
        cmd(0, 16'h0050);
        cmd(0, 16'h0060); cmd(0, 16'h0001);
        chk("R8", 8'h00, 1, 1, 16'h8080);
        cmd(0, 16'h0050);
        cmd(0, 16'h0060); cmd(0, 16'h00D0);
        chk("R8", 8'h00, 1, 1, 16'h8080);
        cmd(0, 16'h0060); cmd(0, 16'h0033);
        chk("R8", 8'h80, 1, 1, 16'h6666);

        // R9 buffered write, count 1 -> two data writes, then confirm
        cmd(0, 16'h0050);
        cmd(8'h90, 16'h00E8);
        cmd(8'h90, 16'h0101);
        cmd(8'h90, 16'h1111);
        cmd(8'h92, 16'h2222);
        cmd(8'h90, 16'h00D0);
        chk("R9", 8'h00, 1, 1, 16'h8080);
        cmd(0, 16'h00FF);
        chk("R9", 8'h90, 1, 1, 16'h1111);
        chk("R9", 8'h92, 1, 1, 16'h2222);
        // R9 count masked to 0 -> one data write, bad confirm -> array
        cmd(8'h94, 16'h00E8);
        cmd(8'h94, 16'h0100);
        cmd(8'h94, 16'h3333);
        cmd(8'h94, 16'h0077);
        chk("R9", 8'h94, 1, 1, 16'h3333);

        // R10 identification
        cmd(0, 16'h0090);
        chk("R10", 8'h00, 1, 1, 16'h8989);
        chk("R10", 8'h02, 1, 1, 16'h1818);
        chk("R10", 8'h04, 1, 1, 16'h0000);

        // R11 query and exit
        cmd(0, 16'h0098);
        chk("R11", 8'h20, 1, 1, 16'h5151);
        chk("R11", 8'h22, 1, 1, 16'h5252);
        chk("R11", 8'h24, 1, 1, 16'h5959);
        cmd(0, 16'h0070);
        chk("R11", 8'h10, 1, 1, 16'h1234);

        // R12 unknown command
        cmd(0, 16'h0070);
        cmd(0, 16'h0033);
        chk("R12", 8'h10, 1, 1, 16'h1234);

        // R14 non-secure accesses
        cmd(0, 16'h0070);
        chk("R14", 8'h10, 1, 0, 16'h1234);
        chk("R14", 8'h10, 1, 1, 16'h8080);
        wr(0, 16'h00FF, 1, 0);
        chk("R14", 8'h10, 1, 1, 16'h8080);
        cmd(0, 16'h00FF);
        wr(0, 16'h0040, 1, 0);
        wr(8'h10, 16'h0000, 1, 0);
        chk("R14", 8'h10, 1, 1, 16'h1234);

        // Random phase: erase all, then mixed program/erase/read vs model
        for (int s = 0; s < 4; s++) begin
            cmd(8'(s*64), 16'h0020);
            cmd(8'(s*64), 16'h00D0);
        end
        cmd(0, 16'h00FF);
        for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
        for (int it = 0; it < 200; it++) begin
            int op = $urandom % 4;
            int a = ($urandom % 128) * 2;
            cfg_msb_first = 1'($urandom % 2);
            if (op < 2) begin
                logic [15:0] d = 16'($urandom);
                cmd(8'(a), op == 0 ? 16'h0010 : 16'h0040);
                cmd(8'(a), d);
                mdl_prog(a, d, cfg_msb_first);
                cmd(0, 16'h00FF);
                chk("R2", 8'(a), 1, 1, mdl_word(a, cfg_msb_first));
            end else if (op == 2) begin
                int s = $urandom % 4;
                int ea = s * 64 + ($urandom % 64);
                cmd(8'(ea), ($urandom % 2) ? 16'h0020 : 16'h0028);
                cmd(8'(ea), 16'h00D0);
                for (int i = 0; i < 64; i++) mdl[s*64 + i] = 8'hFF;
                cmd(0, 16'h00FF);
                chk("R4", 8'(s*64 + (a % 64)), 1, 1, mdl_word(s*64 + (a % 64), cfg_msb_first));
            end else begin
                int b = $urandom % 256;
                chk("R13", 8'(b), 0, 1, {8'h00, mdl[b]});
                chk("R13", 8'(a), 1, 1, mdl_word(a, cfg_msb_first));
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule